// File: doc/BRIEF.md
# I2C Target with Halt Wake-Up

This block is the target side of a two-wire serial bus for a device that can park itself in a low-power halt state. It oversamples SCL and SDA on the system clock, recognises START and STOP conditions, collects the seven-bit address and the direction bit, and answers with an acknowledge or a refusal. It then moves data bytes in either direction through a simple strobe interface towards the core. Both bus lines are open-drain: the block only ever pulls a line low, through `sda_oe` and `scl_oe`.

The core can ask the interface to halt while the bus is free. Any line movement seen while halted wakes the block at once. The first address phase that follows a wake-up is always refused, whatever the address, so the controller is expected to abort with STOP and retry. A START byte (value 0x01 on the wire) is never acknowledged. It counts as that refused address phase, so a controller can use it purely as a wake-up. While the core reports that it is busy, the block holds SCL low after an acknowledge and releases it once the core is ready.

Top module: `i2c_halt_target`

## Requirements
- R1: After reset both line drivers are released (`sda_oe`=0, `scl_oe`=0), `awake` is 1 and neither `wr_valid` nor `rd_req` is asserted.
- R2: When awake, an address byte whose upper seven bits equal the `OWN_ADDR` parameter is acknowledged by pulling SDA low through the ninth SCL high phase. With bit 0 = 0 (write), every following data byte is acknowledged the same way, and `wr_valid` pulses once with the byte on `wr_data`.
- R3: An address that does not match is refused (SDA left released on the ninth clock). The rest of that transaction produces no `wr_valid` or `rd_req` pulse.
- R4: A one-cycle or longer `halt_req` while no transaction is open (between a STOP or reset and the next START) drops `awake` within two cycles. `halt_req` between START and STOP has no effect on `awake`.
- R5: While halted, any edge on SCL or SDA raises `awake` within three clock cycles.
- R6: The first address phase completed after a wake-up is refused even when it matches. A retried matching address is acknowledged normally.
- R7: The address byte 0x01 is never acknowledged, whether halted or awake. When it follows a wake-up it uses up the refusal, so a matching address after a repeated START is acknowledged.
- R8: After an acknowledged read address (bit 0 = 1), the block takes a byte from `rd_data`, pulses `rd_req`, and shifts it out MSB first. It loads the next byte while the controller acknowledges. After a controller NACK it keeps SDA released until the next START or STOP.
- R9: If `core_busy` is high when the ninth clock of an acknowledged byte falls, `scl_oe` holds SCL low until `core_busy` is low, and is released within two cycles after that. A read byte is only taken from `rd_data` while `core_busy` is low.
- R10: A repeated START at any point restarts address reception. A STOP releases both SDA and SCL.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level as seen at the pad |
| sda_i | input | 1 | SDA line level as seen at the pad |
| scl_oe | output | 1 | 1 pulls SCL low (clock stretching) |
| sda_oe | output | 1 | 1 pulls SDA low (acknowledge or read data 0) |
| halt_req | input | 1 | Request to enter the halt state, honoured only while the bus is free |
| awake | output | 1 | 1 when active, 0 while halted |
| core_busy | input | 1 | Core not ready; stall the bus after an acknowledge |
| rd_data | input | 8 | Next byte to send on a read |
| rd_req | output | 1 | One-cycle pulse: `rd_data` was taken |
| wr_valid | output | 1 | One-cycle pulse: a received byte is on `wr_data` |
| wr_data | output | 8 | Last received byte |

## Verification
A change on the bus lines reaches the control logic after two synchroniser stages plus one edge-detect register. Driver outputs, `wr_valid` and `awake` therefore move two to three cycles after the line event that causes them. The bench controller waits at least four cycles after each SCL edge before it touches SDA, and it samples SDA in the middle of a twenty-cycle high phase, so each acknowledge and read bit is read long after it has settled. Level checks on `awake` and `scl_oe` are made three or more cycles after the stimulus, with the two-cycle release bound of R9 checked exactly. Strobe results are counted by a negedge monitor and compared once the transaction that should cause them is complete.

// File: rtl/i2c_wake_pkg.sv
package i2c_wake_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_WR_BITS,
        ST_WR_ACK,
        ST_RD_PREP,
        ST_RD_BITS,
        ST_RD_ACK,
        ST_IGNORE
    } tgt_state_e;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det,
    output logic any_edge
);

    typedef struct packed {
        logic [STAGES-1:0] scl_ff;
        logic [STAGES-1:0] sda_ff;
        logic              scl_p;
        logic              sda_p;
    } sync_t;

    sync_t q, d;
    logic  scl_s;

    assign scl_s = q.scl_ff[STAGES-1];
    assign sda_s = q.sda_ff[STAGES-1];

    always_comb begin
        d        = q;
        d.scl_ff = {q.scl_ff[STAGES-2:0], scl_i};
        d.sda_ff = {q.sda_ff[STAGES-2:0], sda_i};
        d.scl_p  = scl_s;
        d.sda_p  = sda_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{scl_ff: '1, sda_ff: '1, scl_p: 1'b1, sda_p: 1'b1};
        end else begin
            q <= d;
        end
    end

    assign scl_rise  = scl_s & ~q.scl_p;
    assign scl_fall  = ~scl_s & q.scl_p;
    assign start_det = scl_s & q.scl_p & q.sda_p & ~sda_s;
    assign stop_det  = scl_s & q.scl_p & ~q.sda_p & sda_s;
    assign any_edge  = (scl_s ^ q.scl_p) | (sda_s ^ q.sda_p);

endmodule

// File: rtl/i2c_wake_ctrl.sv
module i2c_wake_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic halt_req,
    input  logic start_det,
    input  logic stop_det,
    input  logic any_edge,
    input  logic addr_done,
    output logic awake,
    output logic wake_nack
);

    typedef struct packed {
        logic awake;
        logic busy;
        logic wake_nack;
    } wake_t;

    wake_t q, d;

    always_comb begin
        d = q;
        if (start_det) begin
            d.busy = 1'b1;
        end else if (stop_det) begin
            d.busy = 1'b0;
        end
        if (addr_done) begin
            d.wake_nack = 1'b0;
        end
        if (q.awake) begin
            if (halt_req && !q.busy && !start_det) begin
                d.awake = 1'b0;
            end
        end else if (any_edge) begin
            d.awake     = 1'b1;
            d.wake_nack = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{awake: 1'b1, busy: 1'b0, wake_nack: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign awake     = q.awake;
    assign wake_nack = q.wake_nack;

endmodule

// File: rtl/i2c_target_fsm.sv
module i2c_target_fsm
    import i2c_wake_pkg::*;
#(
    parameter int          ADDR_W   = 7,
    parameter logic [ADDR_W-1:0] OWN_ADDR = 7'h3A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              wake_nack,
    input  logic              core_busy,
    input  logic [ADDR_W:0]   rd_data,
    output logic              sda_oe,
    output logic              scl_oe,
    output logic              wr_valid,
    output logic [ADDR_W:0]   wr_data,
    output logic              rd_req,
    output logic              addr_done
);

    localparam int FRAME_W = ADDR_W + 1;
    localparam int CNT_W   = $clog2(FRAME_W + 1);
    localparam logic [CNT_W-1:0]   CNT_FULL   = CNT_W'(FRAME_W);
    localparam logic [FRAME_W-1:0] START_BYTE = FRAME_W'(1);

    typedef struct packed {
        tgt_state_e         state;
        logic [CNT_W-1:0]   cnt;
        logic [FRAME_W-1:0] sr;
        logic               rw;
        logic               mack;
        logic               stretch;
        logic               sda_oe;
        logic               scl_oe;
        logic               wr_valid;
        logic               rd_req;
        logic               addr_done;
    } fsm_t;

    fsm_t q, d;

    always_comb begin
        d           = q;
        d.wr_valid  = 1'b0;
        d.rd_req    = 1'b0;
        d.addr_done = 1'b0;
        if (stop_det) begin
            d.state   = ST_IDLE;
            d.cnt     = '0;
            d.sda_oe  = 1'b0;
            d.stretch = 1'b0;
        end else if (start_det) begin
            d.state   = ST_ADDR;
            d.cnt     = '0;
            d.sda_oe  = 1'b0;
            d.stretch = 1'b0;
        end else begin
            unique case (q.state)
                ST_ADDR: begin
                    if (scl_rise && q.cnt != CNT_FULL) begin
                        d.sr  = {q.sr[FRAME_W-2:0], sda_s};
                        d.cnt = q.cnt + CNT_W'(1);
                    end else if (scl_fall && q.cnt == CNT_FULL) begin
                        d.addr_done = 1'b1;
                        if (q.sr == START_BYTE || wake_nack ||
                            q.sr[FRAME_W-1:1] != OWN_ADDR) begin
                            d.state = ST_IGNORE;
                        end else begin
                            d.state  = ST_AACK;
                            d.sda_oe = 1'b1;
                            d.rw     = q.sr[0];
                        end
                    end
                end
                ST_AACK, ST_WR_ACK: begin
                    if (scl_fall) begin
                        d.sda_oe = 1'b0;
                        d.cnt    = '0;
                        if (q.rw) begin
                            d.state = ST_RD_PREP;
                        end else begin
                            d.state   = ST_WR_BITS;
                            d.stretch = core_busy;
                        end
                    end
                end
                ST_WR_BITS: begin
                    if (q.stretch && !core_busy) begin
                        d.stretch = 1'b0;
                    end
                    if (scl_rise && q.cnt != CNT_FULL) begin
                        d.sr  = {q.sr[FRAME_W-2:0], sda_s};
                        d.cnt = q.cnt + CNT_W'(1);
                    end else if (scl_fall && q.cnt == CNT_FULL) begin
                        d.wr_valid = 1'b1;
                        d.state    = ST_WR_ACK;
                        d.sda_oe   = 1'b1;
                    end
                end
                ST_RD_PREP: begin
                    if (!core_busy) begin
                        d.sr     = rd_data;
                        d.rd_req = 1'b1;
                        d.sda_oe = ~rd_data[FRAME_W-1];
                        d.state  = ST_RD_BITS;
                        d.cnt    = '0;
                    end
                end
                ST_RD_BITS: begin
                    if (scl_rise && q.cnt != CNT_FULL) begin
                        d.cnt = q.cnt + CNT_W'(1);
                    end else if (scl_fall) begin
                        if (q.cnt == CNT_FULL) begin
                            d.state  = ST_RD_ACK;
                            d.sda_oe = 1'b0;
                        end else begin
                            d.sr     = {q.sr[FRAME_W-2:0], 1'b0};
                            d.sda_oe = ~q.sr[FRAME_W-2];
                        end
                    end
                end
                ST_RD_ACK: begin
                    if (scl_rise) begin
                        d.mack = ~sda_s;
                    end else if (scl_fall) begin
                        d.state = q.mack ? ST_RD_PREP : ST_IGNORE;
                    end
                end
                default: ;
            endcase
        end
        d.scl_oe = d.stretch | (d.state == ST_RD_PREP);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{state: ST_IDLE, cnt: '0, sr: '0, rw: 1'b0, mack: 1'b0,
                   stretch: 1'b0, sda_oe: 1'b0, scl_oe: 1'b0,
                   wr_valid: 1'b0, rd_req: 1'b0, addr_done: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign sda_oe    = q.sda_oe;
    assign scl_oe    = q.scl_oe;
    assign wr_valid  = q.wr_valid;
    assign wr_data   = q.sr;
    assign rd_req    = q.rd_req;
    assign addr_done = q.addr_done;

endmodule

// File: rtl/i2c_halt_target.sv
module i2c_halt_target #(
    parameter int                ADDR_W      = 7,
    parameter logic [ADDR_W-1:0] OWN_ADDR    = 7'h3A,
    parameter int                SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            scl_i,
    input  logic            sda_i,
    output logic            scl_oe,
    output logic            sda_oe,
    input  logic            halt_req,
    output logic            awake,
    input  logic            core_busy,
    input  logic [ADDR_W:0] rd_data,
    output logic            rd_req,
    output logic            wr_valid,
    output logic [ADDR_W:0] wr_data
);

    logic sda_s;
    logic scl_rise;
    logic scl_fall;
    logic start_det;
    logic stop_det;
    logic any_edge;
    logic addr_done;
    logic wake_nack;

    i2c_line_sync #(
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det),
        .any_edge (any_edge)
    );

    i2c_wake_ctrl u_wake (
        .clk      (clk),
        .rst_n    (rst_n),
        .halt_req (halt_req),
        .start_det(start_det),
        .stop_det (stop_det),
        .any_edge (any_edge),
        .addr_done(addr_done),
        .awake    (awake),
        .wake_nack(wake_nack)
    );

    i2c_target_fsm #(
        .ADDR_W  (ADDR_W),
        .OWN_ADDR(OWN_ADDR)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det),
        .wake_nack(wake_nack),
        .core_busy(core_busy),
        .rd_data  (rd_data),
        .sda_oe   (sda_oe),
        .scl_oe   (scl_oe),
        .wr_valid (wr_valid),
        .wr_data  (wr_data),
        .rd_req   (rd_req),
        .addr_done(addr_done)
    );

endmodule

// File: rtl/i2c_halt_target_chk.sv
module i2c_halt_target_chk (
    input logic clk,
    input logic rst_n,
    input logic halt_req,
    input logic core_busy,
    input logic awake,
    input logic sda_oe,
    input logic scl_oe,
    input logic wr_valid,
    input logic rd_req,
    input logic stop_det,
    input logic any_edge
);

    a_r4_halt_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(awake) |-> $past(halt_req));

    a_r5_wake_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (!awake && any_edge) |=> awake);

    a_r10_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (!sda_oe && !scl_oe));

    a_r9_stretch_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_oe && core_busy && !stop_det) |=> scl_oe);

    a_r9_load_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> $past(!core_busy));

    a_r2_write_acked: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> sda_oe);

endmodule

bind i2c_halt_target i2c_halt_target_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .halt_req (halt_req),
    .core_busy(core_busy),
    .awake    (awake),
    .sda_oe   (sda_oe),
    .scl_oe   (scl_oe),
    .wr_valid (wr_valid),
    .rd_req   (rd_req),
    .stop_det (stop_det),
    .any_edge (any_edge)
);

// File: tb/test_i2c_halt_target.sv
`timescale 1ns/1ps
module test_i2c_halt_target;

    localparam logic [6:0] OWN = 7'h3A;
    localparam int         H   = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       halt_req = 1'b0;
    logic       core_busy = 1'b0;
    logic [7:0] rd_data = 8'h00;
    logic       scl_oe, sda_oe, awake, rd_req, wr_valid;
    logic [7:0] wr_data;
    logic       scl_line, sda_line;

    int n_chk = 0;
    int n_bad = 0;
    int wr_cnt = 0;
    int rd_cnt = 0;
    logic [7:0] last_wr = 8'h00;

    always #4 clk = ~clk;

    assign scl_line = scl_m & ~scl_oe;
    assign sda_line = sda_m & ~sda_oe;

    i2c_halt_target #(.OWN_ADDR(OWN)) i_i2c_halt_target (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .halt_req(halt_req), .awake(awake),
        .core_busy(core_busy), .rd_data(rd_data), .rd_req(rd_req),
        .wr_valid(wr_valid), .wr_data(wr_data)
    );

    always @(negedge clk) begin
        if (wr_valid) begin
            wr_cnt  <= wr_cnt + 1;
            last_wr <= wr_data;
        end
        if (rd_req) rd_cnt <= rd_cnt + 1;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_scl_high();
        while (!scl_line) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b0; wt(H);
        scl_m = 1'b0; wt(H);
    endtask

    task automatic bus_rstart();
        sda_m = 1'b1; wt(H);
        scl_m = 1'b1; wait_scl_high(); wt(H);
        sda_m = 1'b0; wt(H);
        scl_m = 1'b0; wt(H);
    endtask

    task automatic bus_stop();
        wt(4);
        sda_m = 1'b0; wt(H);
        scl_m = 1'b1; wait_scl_high(); wt(H);
        sda_m = 1'b1; wt(H);
    endtask

    task automatic bit_xfer(input logic b, output logic r);
        wt(4);
        sda_m = b; wt(H);
        scl_m = 1'b1; wait_scl_high();
        wt(H/2); r = sda_line; wt(H/2);
        scl_m = 1'b0;
    endtask

    task automatic byte_tx(input logic [7:0] v, output logic acked);
        logic r;
        for (int i = 7; i >= 0; i--) bit_xfer(v[i], r);
        bit_xfer(1'b1, r);
        acked = !r;
    endtask

    task automatic byte_rx(input logic give_ack, output logic [7:0] v);
        logic r;
        for (int i = 7; i >= 0; i--) begin
            bit_xfer(1'b1, r);
            v[i] = r;
        end
        bit_xfer(!give_ack, r);
    endtask

    task automatic t_reset();
        wt(5); rst_n = 1'b1; wt(2);
        chk("R1 sda_oe", sda_oe, 0);
        chk("R1 scl_oe", scl_oe, 0);
        chk("R1 awake", awake, 1);
        chk("R1 strobes", {wr_valid, rd_req}, 0);
    endtask

    task automatic t_write();
        logic a;
        int w0 = wr_cnt;
        bus_start();
        byte_tx({OWN, 1'b0}, a); chk("R2 addr ack", a, 1);
        byte_tx(8'hC3, a);       chk("R2 data ack", a, 1);
        chk("R2 byte C3", last_wr, 8'hC3);
        byte_tx(8'h0F, a);       chk("R2 data ack 2", a, 1);
        chk("R2 byte 0F", last_wr, 8'h0F);
        chk("R2 strobe count", wr_cnt - w0, 2);
        bus_stop(); wt(5);
        chk("R10 released after stop", {sda_oe, scl_oe}, 0);
    endtask

    task automatic t_nomatch();
        logic a;
        int w0 = wr_cnt;
        int r0 = rd_cnt;
        bus_start();
        byte_tx({7'h23, 1'b0}, a); chk("R3 write nack", a, 0);
        byte_tx(8'h55, a);         chk("R3 data ignored", a, 0);
        bus_stop();
        bus_start();
        byte_tx({7'h23, 1'b1}, a); chk("R3 read nack", a, 0);
        bus_stop(); wt(5);
        chk("R3 no wr strobe", wr_cnt - w0, 0);
        chk("R3 no rd strobe", rd_cnt - r0, 0);
    endtask

    task automatic t_read();
        logic a;
        logic [7:0] v;
        int r0 = rd_cnt;
        rd_data = 8'hA5;
        bus_start();
        byte_tx({OWN, 1'b1}, a); chk("R8 read addr ack", a, 1);
        wt(10); rd_data = 8'h3C;
        byte_rx(1'b1, v); chk("R8 first byte", v, 8'hA5);
        byte_rx(1'b0, v); chk("R8 second byte", v, 8'h3C);
        byte_rx(1'b0, v); chk("R8 released after nack", v, 8'hFF);
        bus_stop(); wt(5);
        chk("R8 load count", rd_cnt - r0, 2);
    endtask

    task automatic t_halt_busy();
        logic a;
        bus_start();
        byte_tx({OWN, 1'b0}, a); chk("R4 ack before halt try", a, 1);
        halt_req = 1'b1; wt(3); halt_req = 1'b0; wt(3);
        chk("R4 halt ignored mid-transfer", awake, 1);
        bus_stop(); wt(5);
        chk("R4 still awake after stop", awake, 1);
    endtask

    task automatic t_halt_wake();
        logic a;
        halt_req = 1'b1; wt(1); halt_req = 1'b0; wt(2);
        chk("R4 halted", awake, 0);
        wt(20);
        chk("R4 stays halted", awake, 0);
        sda_m = 1'b0; wt(4);
        chk("R5 woken by edge", awake, 1);
        wt(H); scl_m = 1'b0; wt(H);
        byte_tx({OWN, 1'b0}, a); chk("R6 first address refused", a, 0);
        bus_stop();
        bus_start();
        byte_tx({OWN, 1'b0}, a); chk("R6 retry acked", a, 1);
        byte_tx(8'h5A, a);       chk("R6 retry data ack", a, 1);
        chk("R6 retry byte", last_wr, 8'h5A);
        bus_stop();
    endtask

    task automatic t_start_byte();
        logic a;
        halt_req = 1'b1; wt(1); halt_req = 1'b0; wt(3);
        chk("R7 halted", awake, 0);
        bus_start();
        chk("R7 woken by start", awake, 1);
        byte_tx(8'h01, a); chk("R7 start byte nack", a, 0);
        bus_rstart();
        byte_tx({OWN, 1'b0}, a); chk("R7 ack after start byte", a, 1);
        bus_stop();
        bus_start();
        byte_tx(8'h01, a); chk("R7 start byte nack awake", a, 0);
        bus_stop();
    endtask

    task automatic t_stretch();
        logic a;
        core_busy = 1'b1;
        bus_start();
        byte_tx({OWN, 1'b0}, a); chk("R9 addr ack", a, 1);
        wt(10);
        chk("R9 stretch on", scl_oe, 1);
        wt(60);
        chk("R9 stretch held", {scl_oe, scl_line}, 2'b10);
        core_busy = 1'b0; wt(2);
        chk("R9 stretch released", scl_oe, 0);
        byte_tx(8'h96, a); chk("R9 data ack", a, 1);
        chk("R9 byte after stall", last_wr, 8'h96);
        bus_stop();
    endtask

    task automatic t_restart();
        logic a, r;
        bus_start();
        byte_tx({OWN, 1'b0}, a); chk("R10 addr ack", a, 1);
        bit_xfer(1'b1, r); bit_xfer(1'b0, r); bit_xfer(1'b1, r);
        bus_rstart();
        byte_tx({OWN, 1'b0}, a); chk("R10 ack after restart", a, 1);
        byte_tx(8'h77, a);       chk("R10 data ack", a, 1);
        chk("R10 byte aligned", last_wr, 8'h77);
        bus_stop(); wt(5);
        chk("R10 lines free", {sda_oe, scl_oe}, 0);
    endtask

    initial begin
        repeat (150000) @(negedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_write();
        t_nomatch();
        t_read();
        t_halt_busy();
        t_halt_wake();
        t_start_byte();
        t_stretch();
        t_restart();
        wt(10);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule